// File: doc/BRIEF.md
# Calendar Clock Counter with Control Register

This block keeps wall-clock time and a calendar date from a one-second tick. Seconds, minutes and hours feed a day, month and two-digit year chain. The month length depends on the month and on a leap flag that is derived from the year. Hours run either from 0 to 23 or from 12 through 11, and a separate p.m. bit distinguishes the two halves of the day in the 12-hour case.

Software reaches every field through one byte-wide register port. Writes are synchronous and reads are combinational. An 8-bit control register holds these bits:
- run/stop
- hour-format select
- the p.m. bit
- a soft reset, which stays in force for as long as it holds 1
- an event-output enable
- a stored correction-enable bit, which has no effect of its own

The tick is taken on its rising edge. Before the counters change on a tick, a busy flag is raised for exactly one clock cycle. Software must not trust time values, and time writes are dropped, while busy is high.

Register map (3-bit address, binary field values): 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 control. Control bits are: 7 run, 6 24-hour select, 5 p.m., 4 soft reset, 3 reserved, 2 leap (read-only), 1 event-output enable, 0 correction enable.

Top module: `rtc_calendar`

## Requirements
- R1: After hardware reset the control register reads 0x04, and the fields read as follows: seconds 0, minutes 0, hours 12, day 1, month 1, year 0. busy is 0.
- R2: While run (control bit 7) is 0, ticks are ignored. busy stays 0 and every time field keeps its value.
- R3: With run at 1, a rising tick edge raises busy for exactly one cycle. Seconds advance on the edge that ends that cycle. Seconds wrap from 59 to 0 with a carry into minutes, and minutes wrap from 59 to 0 with a carry into hours. A tick held high for several cycles counts once.
- R4: In 24-hour mode (bit 6 = 1) hours run 0 to 23. The day advances when 23:59:59 passes.
- R5: In 12-hour mode (bit 6 = 0) hours run 12, 1, ..., 11. The p.m. bit (bit 5) toggles when 11:59:59 goes to 12:00:00. The day advances only when p.m. was 1 at that moment.
- R6: April, June, September and November have 30 days, and the other months other than February have 31. February has 29 days when the leap flag is 1 and 28 otherwise. After the last day of a month, the day goes to 1 and the month advances. After the last day of month 12, the month goes to 1 and the year advances.
- R7: The leap flag (control bit 2) reads 1 exactly when the year is a multiple of four, 0 included. The year wraps from 99 to 0.
- R8: While the soft-reset bit (bit 4) holds 1, the fields are held at these values: year 0 (so leap reads 1), seconds 0, minutes 0, day 1, month 1, hours 0 in 24-hour mode or 12 in 12-hour mode, and p.m. 0. Ticks are ignored.
- R9: Writes to addresses 0 to 5 are ignored while busy is 1 or while soft reset holds 1.
- R10: Writes to control bits 3 and 2 are ignored. Bit 3 always reads 0.
- R11: With bit 1 set, the event output pulses for one cycle in the cycle after busy. With bit 1 clear, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second time base, used on its rising edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| busy | output | 1 | Counter update in progress |
| evt_out | output | 1 | One-cycle pulse per update when enabled |

## Verification
The counting chain is tried with preset times that sit just before each carry boundary:
- a plain seconds step
- a seconds wrap
- a minutes wrap
- the end of a day in both hour formats
- month ends of 30 and 31 days
- February in leap and ordinary years, year 0 included
- the year wrap from 99

Each preset separates one carry path from its neighbours. Comparing the 12-hour cases with p.m. at 0 and at 1 shows whether the day carry is tied to the p.m. bit. Directed patterns cover several cases:
- a stopped clock
- a held tick
- writes in the busy cycle and under soft reset
- reserved control bits
- the event output with its enable on and off

Together these show that each gating condition blocks exactly what it should.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADR_W   = 3;
    localparam int DATA_W  = 8;
    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HR_W    = 5;
    localparam int DAY_W   = 5;
    localparam int MON_W   = 4;
    localparam int YR_W    = 7;

    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HR24_LAST = 23;
    localparam int HR12_TOP  = 12;
    localparam int HR12_PRE  = 11;
    localparam int MON_LAST  = 12;
    localparam int YR_LAST   = 99;
    localparam int LEAP_STEP = 4;

    localparam logic [ADR_W-1:0] AD_SEC  = 3'd0;
    localparam logic [ADR_W-1:0] AD_MIN  = 3'd1;
    localparam logic [ADR_W-1:0] AD_HOUR = 3'd2;
    localparam logic [ADR_W-1:0] AD_DAY  = 3'd3;
    localparam logic [ADR_W-1:0] AD_MON  = 3'd4;
    localparam logic [ADR_W-1:0] AD_YEAR = 3'd5;
    localparam logic [ADR_W-1:0] AD_CTRL = 3'd6;

    localparam int CB_RUN  = 7;
    localparam int CB_H24  = 6;
    localparam int CB_PM   = 5;
    localparam int CB_SRST = 4;
    localparam int CB_OE   = 1;
    localparam int CB_AADJ = 0;

    // Last day number of a month, given the leap flag
    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] mon,
                                                   input logic leap);
        logic [DAY_W-1:0] n;
        case (mon)
            MON_W'(2):                                    n = leap ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11):  n = DAY_W'(30);
            default:                                      n = DAY_W'(31);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pm_flip,
    output logic              run,
    output logic              hr24,
    output logic              pm,
    output logic              srst,
    output logic              oe,
    output logic              aadj,
    output logic              busy,
    output logic              evt
);

    typedef struct packed {
        logic run;
        logic hr24;
        logic pm;
        logic srst;
        logic oe;
        logic aadj;
        logic tick_seen;
        logic pend;
        logic evt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.tick_seen = tick;
        // R3: one update per rising tick edge, only while running (R2)
        st_d.pend      = tick & ~st_q.tick_seen & st_q.run & ~st_q.srst;
        // R11: event follows the busy cycle when enabled
        st_d.evt       = st_q.pend & st_q.oe;
        if (pm_flip) begin
            st_d.pm = ~st_q.pm;
        end
        if (wr_en) begin
            // R10: bits 3 and 2 are not stored
            st_d.run  = wdata[CB_RUN];
            st_d.hr24 = wdata[CB_H24];
            st_d.pm   = wdata[CB_PM];
            st_d.srst = wdata[CB_SRST];
            st_d.oe   = wdata[CB_OE];
            st_d.aadj = wdata[CB_AADJ];
        end
        // R8: soft reset clears p.m. and cancels a pending update
        if (st_d.srst) begin
            st_d.pm   = 1'b0;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run  = st_q.run;
    assign hr24 = st_q.hr24;
    assign pm   = st_q.pm;
    assign srst = st_q.srst;
    assign oe   = st_q.oe;
    assign aadj = st_q.aadj;
    assign busy = st_q.pend;
    assign evt  = st_q.evt;

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              srst,
    input  logic              hr24,
    input  logic              pm,
    input  logic              wr_en,
    input  logic [ADR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEC_W-1:0]  sec,
    output logic [MIN_W-1:0]  min,
    output logic [HR_W-1:0]   hour,
    output logic              pm_flip,
    output logic              day_carry
);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [HR_W-1:0]  hour;
    } time_st_t;

    time_st_t st_d, st_q;
    logic     sec_wrap, min_wrap, hour_roll;
    logic     at_day_end;
    logic [HR_W-1:0] hour_next;
    logic [HR_W-1:0] hour_init;

    always_comb begin
        sec_wrap  = (st_q.sec == SEC_W'(SEC_LAST));
        min_wrap  = (st_q.min == MIN_W'(MIN_LAST));
        hour_roll = adv & sec_wrap & min_wrap;
        hour_init = hr24 ? '0 : HR_W'(HR12_TOP);
        // R4 / R5: hour sequence per format
        if (hr24 && st_q.hour == HR_W'(HR24_LAST)) begin
            hour_next = '0;
        end else if (!hr24 && st_q.hour == HR_W'(HR12_TOP)) begin
            hour_next = HR_W'(1);
        end else begin
            hour_next = st_q.hour + HR_W'(1);
        end
        at_day_end = hr24 ? (st_q.hour == HR_W'(HR24_LAST))
                          : (st_q.hour == HR_W'(HR12_PRE) && pm);
        pm_flip    = hour_roll & ~hr24 & (st_q.hour == HR_W'(HR12_PRE));
        day_carry  = hour_roll & at_day_end;

        st_d = st_q;
        if (srst) begin
            // R8: held at the start of day
            st_d.sec  = '0;
            st_d.min  = '0;
            st_d.hour = hour_init;
        end else if (adv) begin
            // R3: seconds, minutes, hours carry chain
            st_d.sec = sec_wrap ? '0 : st_q.sec + SEC_W'(1);
            if (sec_wrap) begin
                st_d.min = min_wrap ? '0 : st_q.min + MIN_W'(1);
            end
            if (hour_roll) begin
                st_d.hour = hour_next;
            end
        end else if (wr_en) begin
            case (wr_addr)
                AD_SEC:  st_d.sec  = wdata[SEC_W-1:0];
                AD_MIN:  st_d.min  = wdata[MIN_W-1:0];
                AD_HOUR: st_d.hour = wdata[HR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sec  <= '0;
            st_q.min  <= '0;
            st_q.hour <= HR_W'(HR12_TOP);
        end else begin
            st_q <= st_d;
        end
    end

    assign sec  = st_q.sec;
    assign min  = st_q.min;
    assign hour = st_q.hour;

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              day_carry,
    input  logic              srst,
    input  logic              wr_en,
    input  logic [ADR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DAY_W-1:0]  day,
    output logic [MON_W-1:0]  mon,
    output logic [YR_W-1:0]   year,
    output logic              leap
);

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [MON_W-1:0] mon;
        logic [YR_W-1:0]  year;
    } date_st_t;

    date_st_t st_d, st_q;
    logic     month_end, year_end;

    always_comb begin
        // R7: leap when the year is a multiple of four
        leap      = ((st_q.year % YR_W'(LEAP_STEP)) == '0);
        // R6: month length from month and leap flag
        month_end = (st_q.day == month_len(st_q.mon, leap));
        year_end  = (st_q.mon == MON_W'(MON_LAST));

        st_d = st_q;
        if (srst) begin
            st_d.day  = DAY_W'(1);
            st_d.mon  = MON_W'(1);
            st_d.year = '0;
        end else if (day_carry) begin
            if (month_end) begin
                st_d.day = DAY_W'(1);
                if (year_end) begin
                    st_d.mon  = MON_W'(1);
                    st_d.year = (st_q.year == YR_W'(YR_LAST)) ? '0 : st_q.year + YR_W'(1);
                end else begin
                    st_d.mon = st_q.mon + MON_W'(1);
                end
            end else begin
                st_d.day = st_q.day + DAY_W'(1);
            end
        end else if (wr_en) begin
            case (wr_addr)
                AD_DAY:  st_d.day  = wdata[DAY_W-1:0];
                AD_MON:  st_d.mon  = wdata[MON_W-1:0];
                AD_YEAR: st_d.year = wdata[YR_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.day  <= DAY_W'(1);
            st_q.mon  <= MON_W'(1);
            st_q.year <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign day  = st_q.day;
    assign mon  = st_q.mon;
    assign year = st_q.year;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [ADR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              busy,
    output logic              evt_out
);

    logic              run, hr24, pm, srst, oe, aadj;
    logic              pm_flip, day_carry, leap;
    logic              ctrl_we, time_we;
    logic [SEC_W-1:0]  sec_v;
    logic [MIN_W-1:0]  min_v;
    logic [HR_W-1:0]   hour_v;
    logic [DAY_W-1:0]  day_v;
    logic [MON_W-1:0]  mon_v;
    logic [YR_W-1:0]   year_v;

    assign ctrl_we = reg_wr & (reg_addr == AD_CTRL);
    // R9: time fields are locked during an update and under soft reset
    assign time_we = reg_wr & ~busy & ~srst;

    rtc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (ctrl_we),
        .wdata   (reg_wdata),
        .pm_flip (pm_flip),
        .run     (run),
        .hr24    (hr24),
        .pm      (pm),
        .srst    (srst),
        .oe      (oe),
        .aadj    (aadj),
        .busy    (busy),
        .evt     (evt_out)
    );

    rtc_time_chain u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (busy),
        .srst      (srst),
        .hr24      (hr24),
        .pm        (pm),
        .wr_en     (time_we),
        .wr_addr   (reg_addr),
        .wdata     (reg_wdata),
        .sec       (sec_v),
        .min       (min_v),
        .hour      (hour_v),
        .pm_flip   (pm_flip),
        .day_carry (day_carry)
    );

    rtc_date_chain u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_carry (day_carry),
        .srst      (srst),
        .wr_en     (time_we),
        .wr_addr   (reg_addr),
        .wdata     (reg_wdata),
        .day       (day_v),
        .mon       (mon_v),
        .year      (year_v),
        .leap      (leap)
    );

    always_comb begin
        case (reg_addr)
            AD_SEC:  reg_rdata = DATA_W'(sec_v);
            AD_MIN:  reg_rdata = DATA_W'(min_v);
            AD_HOUR: reg_rdata = DATA_W'(hour_v);
            AD_DAY:  reg_rdata = DATA_W'(day_v);
            AD_MON:  reg_rdata = DATA_W'(mon_v);
            AD_YEAR: reg_rdata = DATA_W'(year_v);
            AD_CTRL: reg_rdata = {run, hr24, pm, srst, 1'b0, leap, oe, aadj};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_calendar_sva.sv
module rtc_calendar_sva
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              evt_out,
    input logic              reg_wr,
    input logic [ADR_W-1:0]  reg_addr,
    input logic              srst,
    input logic              oe,
    input logic              pm,
    input logic              pm_flip,
    input logic              leap,
    input logic [SEC_W-1:0]  sec_v,
    input logic [MIN_W-1:0]  min_v,
    input logic [YR_W-1:0]   year_v
);

    p_busy_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !srst && sec_v != SEC_W'(SEC_LAST)) |=> (sec_v == $past(sec_v) + SEC_W'(1)));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !reg_wr && !srst) |=> ($stable(sec_v) && $stable(min_v) && $stable(year_v)));

    p_srst_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (year_v == '0 && leap && sec_v == '0 && !pm));

    p_evt_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out |-> ($past(busy) && $past(oe)));

    p_pm_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_flip && !srst && !(reg_wr && reg_addr == AD_CTRL)) |=> (pm != $past(pm)));

endmodule

bind rtc_calendar rtc_calendar_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .evt_out  (evt_out),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .srst     (srst),
    .oe       (oe),
    .pm       (pm),
    .pm_flip  (pm_flip),
    .leap     (leap),
    .sec_v    (sec_v),
    .min_v    (min_v),
    .year_v   (year_v)
);

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       busy;
    logic       evt_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rtc_calendar uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .evt_out   (evt_out)
    );

    localparam logic [2:0] A_SEC = 3'd0, A_MIN = 3'd1, A_HOUR = 3'd2, A_DAY = 3'd3,
                           A_MON = 3'd4, A_YEAR = 3'd5, A_CTRL = 3'd6;

    typedef struct packed {
        logic [7:0] h, m, s, d, mo, y;
        logic       h24, pm;
        logic [7:0] eh, em, es, ed, emo, ey;
        logic       epm;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'd10,8'd20,8'd30,8'd5, 8'd3, 8'd10,1'b1,1'b0, 8'd10,8'd20,8'd31,8'd5, 8'd3, 8'd10,1'b0},
        '{8'd10,8'd20,8'd59,8'd5, 8'd3, 8'd10,1'b1,1'b0, 8'd10,8'd21,8'd0, 8'd5, 8'd3, 8'd10,1'b0},
        '{8'd10,8'd59,8'd59,8'd5, 8'd3, 8'd10,1'b1,1'b0, 8'd11,8'd0, 8'd0, 8'd5, 8'd3, 8'd10,1'b0},
        '{8'd23,8'd59,8'd59,8'd5, 8'd3, 8'd10,1'b1,1'b0, 8'd0, 8'd0, 8'd0, 8'd6, 8'd3, 8'd10,1'b0},
        '{8'd23,8'd59,8'd59,8'd30,8'd4, 8'd10,1'b1,1'b0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd5, 8'd10,1'b0},
        '{8'd23,8'd59,8'd59,8'd30,8'd5, 8'd10,1'b1,1'b0, 8'd0, 8'd0, 8'd0, 8'd31,8'd5, 8'd10,1'b0},
        '{8'd23,8'd59,8'd59,8'd28,8'd2, 8'd10,1'b1,1'b0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd3, 8'd10,1'b0},
        '{8'd23,8'd59,8'd59,8'd28,8'd2, 8'd12,1'b1,1'b0, 8'd0, 8'd0, 8'd0, 8'd29,8'd2, 8'd12,1'b0},
        '{8'd23,8'd59,8'd59,8'd29,8'd2, 8'd12,1'b1,1'b0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd3, 8'd12,1'b0},
        '{8'd23,8'd59,8'd59,8'd31,8'd12,8'd99,1'b1,1'b0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd0, 1'b0},
        '{8'd23,8'd59,8'd59,8'd31,8'd12,8'd10,1'b1,1'b0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd11,1'b0},
        '{8'd11,8'd59,8'd59,8'd5, 8'd3, 8'd10,1'b0,1'b0, 8'd12,8'd0, 8'd0, 8'd5, 8'd3, 8'd10,1'b1},
        '{8'd11,8'd59,8'd59,8'd5, 8'd3, 8'd10,1'b0,1'b1, 8'd12,8'd0, 8'd0, 8'd6, 8'd3, 8'd10,1'b0},
        '{8'd12,8'd59,8'd59,8'd5, 8'd3, 8'd10,1'b0,1'b0, 8'd1, 8'd0, 8'd0, 8'd5, 8'd3, 8'd10,1'b0},
        '{8'd23,8'd59,8'd59,8'd30,8'd11,8'd10,1'b1,1'b0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd12,8'd10,1'b0},
        '{8'd23,8'd59,8'd59,8'd28,8'd2, 8'd0, 1'b1,1'b0, 8'd0, 8'd0, 8'd0, 8'd29,8'd2, 8'd0, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // Returns at the negedge where the update is visible
    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, r); chk("R1 ctrl", r, 8'h04);
        rd(A_SEC,  r); chk("R1 sec", r, 8'd0);
        rd(A_MIN,  r); chk("R1 min", r, 8'd0);
        rd(A_HOUR, r); chk("R1 hour", r, 8'd12);
        rd(A_DAY,  r); chk("R1 day", r, 8'd1);
        rd(A_MON,  r); chk("R1 month", r, 8'd1);
        rd(A_YEAR, r); chk("R1 year", r, 8'd0);
        chk("R1 busy", {7'd0, busy}, 8'd0);

        // Vector table: preset, one tick, compare
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            wr(A_CTRL, {1'b0, v.h24, v.pm, 5'b0});
            wr(A_SEC, v.s);  wr(A_MIN, v.m);  wr(A_HOUR, v.h);
            wr(A_DAY, v.d);  wr(A_MON, v.mo); wr(A_YEAR, v.y);
            rd(A_CTRL, r);
            chk("R7 leap flag", {7'd0, r[2]}, {7'd0, (v.y % 8'd4) == 8'd0});
            wr(A_CTRL, {1'b1, v.h24, v.pm, 5'b0});
            pulse_tick();
            rd(A_SEC,  r); chk("R3 seconds", r, v.es);
            rd(A_MIN,  r); chk("R3 minutes", r, v.em);
            rd(A_HOUR, r); chk("R4/R5 hours", r, v.eh);
            rd(A_DAY,  r); chk("R6 day", r, v.ed);
            rd(A_MON,  r); chk("R6 month", r, v.emo);
            rd(A_YEAR, r); chk("R7 year", r, v.ey);
            rd(A_CTRL, r); chk("R5 pm bit", {7'd0, r[5]}, {7'd0, v.epm});
        end

        // R2: stopped clock ignores ticks
        wr(A_CTRL, 8'h40);
        wr(A_SEC, 8'd10);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk("R2 busy while stopped", {7'd0, busy}, 8'd0);
        @(negedge clk);
        rd(A_SEC, r); chk("R2 seconds held", r, 8'd10);

        // R3: busy for exactly one cycle; held tick counts once
        wr(A_CTRL, 8'hC0);
        @(negedge clk); tick = 1'b1;
        @(negedge clk);
        chk("R3 busy raised", {7'd0, busy}, 8'd1);
        @(negedge clk);
        chk("R3 busy one cycle", {7'd0, busy}, 8'd0);
        repeat (4) @(negedge clk);
        tick = 1'b0;
        rd(A_SEC, r); chk("R3 held tick counts once", r, 8'd11);

        // R9: write in the busy cycle is dropped
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        reg_wr = 1'b1; reg_addr = A_SEC; reg_wdata = 8'd40;
        @(negedge clk); reg_wr = 1'b0;
        rd(A_SEC, r); chk("R9 write during busy", r, 8'd12);

        // R11: event output with enable on and off
        wr(A_CTRL, 8'hC2);
        pulse_tick();
        chk("R11 event pulse", {7'd0, evt_out}, 8'd1);
        @(negedge clk);
        chk("R11 event one cycle", {7'd0, evt_out}, 8'd0);
        wr(A_CTRL, 8'hC0);
        pulse_tick();
        chk("R11 event disabled", {7'd0, evt_out}, 8'd0);

        // R10: reserved and read-only control bits
        wr(A_CTRL, 8'h00);
        wr(A_YEAR, 8'd1);
        wr(A_CTRL, 8'h0C);
        rd(A_CTRL, r); chk("R10 bits 3 and 2 ignored", r, 8'h00);

        // R8: soft reset in 12-hour mode with p.m. requested
        wr(A_YEAR, 8'd13);
        wr(A_SEC, 8'd25);
        wr(A_CTRL, 8'hB0);
        @(negedge clk);
        rd(A_YEAR, r); chk("R8 year cleared", r, 8'd0);
        rd(A_CTRL, r); chk("R8 leap set, pm clear", r & 8'h24, 8'h04);
        rd(A_HOUR, r); chk("R8 hour 12h init", r, 8'd12);
        rd(A_SEC, s0);  chk("R8 seconds init", s0, 8'd0);
        pulse_tick();
        rd(A_SEC, r); chk("R8 tick ignored", r, 8'd0);
        wr(A_MIN, 8'd33);
        rd(A_MIN, r); chk("R9 write under soft reset", r, 8'd0);
        wr(A_CTRL, 8'h50);
        @(negedge clk);
        rd(A_HOUR, r); chk("R8 hour 24h init", r, 8'd0);
        wr(A_CTRL, 8'h40);
        wr(A_MIN, 8'd33);
        rd(A_MIN, r); chk("R9 write after release", r, 8'd33);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule